// File: doc/BRIEF.md
# One-shot interrupt countdown timer

This block is a down-counter that a processor programs through a small register window. A control register holds an interrupt vector, a delivery-type field, a mask bit and a mode field. An initial-count register loads the counter, and a read-only current-count register shows how many ticks remain. Each pulse on the tick-enable input decrements a nonzero count by one. When the count reaches zero in one-shot mode with the mask clear, the block raises a one-cycle interrupt request together with the vector that was programmed.

Software starts a countdown by writing a nonzero initial count. It cancels a countdown by writing zero. It can measure elapsed time by reading the current count twice and subtracting the second reading from the first. Loading all ones starts the longest possible countdown. The counter stays at zero once it gets there, so a single load produces at most one interrupt.

Top module: `oneshot_timer`

## Requirements
- R1: After reset the control register reads 0x0001_0000 (mask set, every other field zero), both count registers read 0, and `irq` is low.
- R2: The control register at offset 0x320 stores the vector in bits 7:0, the delivery type in bits 10:8, the mask in bit 16 and the mode in bits 18:17. Every other bit reads back as 0.
- R3: A write of a nonzero value N to offset 0x380 makes both the initial-count register (0x380) and the current-count register (0x390) read N from the next cycle on.
- R4: On each clock edge where `tick` is high and the current count is nonzero, the count drops by exactly one. On edges where `tick` is low, the count holds.
- R5: Writing 0 to offset 0x380 stops the countdown. The count stays at 0 under further ticks and no interrupt follows.
- R6: The edge that moves the count from 1 to 0 makes `irq` high for exactly the next cycle, with `irq_vector` equal to the programmed vector, provided the mask is 0 and the mode is 0 (one-shot). The count then holds at 0 and no second pulse follows.
- R7: With the mask at 1, the count still runs down to 0 but `irq` stays low.
- R8: With a mode value of 1, 2 or 3, the mode is stored and the count runs, but `irq` stays low.
- R9: The delivery-type bits do not change the countdown timing or the interrupt.
- R10: Reads of any offset other than 0x320, 0x380 and 0x390 return 0, and writes to such offsets change no register. A write to 0x390 is ignored.
- R11: Loading 0xFFFF_FFFF is legal. One tick after such a load the count reads 0xFFFF_FFFE.
- R12: If a write to 0x380 lands on the same edge as a tick, the written value is loaded and the tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Countdown enable, one decrement per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector that goes with `irq` |

## Verification
The bench sweeps load values from 1 to 6 against every combination of mask and mode, and counts down tick by tick. A design that fires one cycle early or late, that fires while masked or in a non-one-shot mode, or that fires again once at zero shows up in that sweep. Separate runs go after a load that collides with a tick (a design giving the tick priority would read one less), a zero write in mid-count (a design that lets the count run on would interrupt later), and a maximum-length load (a design that truncates the load width would read a small value). Writes to the read-only and undefined offsets are followed by read-backs, so a leaky decode shows up as changed register contents.

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int AW = 12,
  parameter int CW = 32,
  parameter logic [AW-1:0] CTRL_OFS = 'h320,
  parameter logic [AW-1:0] INIT_OFS = 'h380,
  parameter logic [AW-1:0] CUR_OFS  = 'h390
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq,
  output logic [7:0]    irq_vector
);

  logic [7:0]    vec_q;
  logic [2:0]    dlv_q;
  logic          msk_q;
  logic [1:0]    mode_q;
  logic [CW-1:0] init_q, cur_q;
  logic          irq_q;
  logic [7:0]    ivec_q;

  wire wr_ctrl = bus_wr && (bus_addr == CTRL_OFS);
  wire wr_init = bus_wr && (bus_addr == INIT_OFS);
  wire fire    = tick && (cur_q == CW'(1)) && !wr_init;
  wire unused_wdata = ^{bus_wdata[31:19], bus_wdata[15:11]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q  <= '0;
      dlv_q  <= '0;
      msk_q  <= 1'b1;
      mode_q <= '0;
      init_q <= '0;
      cur_q  <= '0;
      irq_q  <= 1'b0;
      ivec_q <= '0;
    end else begin
      if (wr_ctrl) begin
        vec_q  <= bus_wdata[7:0];
        dlv_q  <= bus_wdata[10:8];
        msk_q  <= bus_wdata[16];
        mode_q <= bus_wdata[18:17];
      end
      if (wr_init) begin
        init_q <= bus_wdata[CW-1:0];
        cur_q  <= bus_wdata[CW-1:0];
      end else if (tick && cur_q != '0) begin
        cur_q <= cur_q - CW'(1);
      end
      irq_q <= fire && !msk_q && (mode_q == 2'd0);
      if (fire) ivec_q <= vec_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_OFS)
      bus_rdata = {13'b0, mode_q, msk_q, 5'b0, dlv_q, vec_q};
    else if (bus_addr == INIT_OFS)
      bus_rdata = 32'(init_q);
    else if (bus_addr == CUR_OFS)
      bus_rdata = 32'(cur_q);
  end

  assign irq        = irq_q;
  assign irq_vector = ivec_q;

  p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cur_q != '0 && !wr_init) |=> (cur_q == $past(cur_q - CW'(1))));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_init) |=> $stable(cur_q));
  p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_init && bus_wdata[CW-1:0] == '0) |=> (cur_q == '0 && !irq));
  p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cur_q == '0));
  p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(!msk_q && mode_q == 2'd0));
  p_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_init |=> (cur_q == $past(bus_wdata[CW-1:0])));

endmodule

// File: tb/sim_oneshot_timer.sv
module sim_oneshot_timer;
  localparam logic [11:0] A_CTRL = 12'h320, A_INIT = 12'h380, A_CUR = 12'h390;

  logic clk = 0, rst_n = 0, tick = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;
  logic [7:0] irq_vector;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  oneshot_timer u0 (.clk, .rst_n, .tick, .bus_wr, .bus_addr, .bus_wdata,
                    .bus_rdata, .irq, .irq_vector);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic run(int n, bit m, logic [1:0] md, logic [7:0] v, logic [2:0] dl);
    logic [31:0] d;
    bit fire_exp;
    wr(A_CTRL, {13'b0, md, m, 5'b0, dl, v});
    rd(A_CTRL, d); check("R2 ctrl readback", d, {13'b0, md, m, 5'b0, dl, v});
    wr(A_INIT, n);
    rd(A_INIT, d); check("R3 init readback", d, n);
    rd(A_CUR, d);  check("R3 cur loaded", d, n);
    tick = 1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      #1 check("R4 countdown", bus_rdata, n - k);
      fire_exp = (k == n) && !m && (md == 0);
      check(m ? "R7 mask" : (md != 0 ? "R8 mode" : (dl != 0 ? "R9 delivery" : "R6 pulse")),
            irq, fire_exp);
      if (fire_exp) check("R6 vector", irq_vector, v);
    end
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      #1 check("R6 single pulse", irq, 0);
      check("R6 hold zero", bus_rdata, 0);
    end
    tick = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(A_CTRL, d); check("R1 ctrl reset", d, 32'h0001_0000);
    rd(A_INIT, d); check("R1 init reset", d, 0);
    rd(A_CUR, d);  check("R1 cur reset", d, 0);
    check("R1 irq reset", irq, 0);

    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d); check("R2 reserved bits", d, 32'h0007_07FF);

    for (int n = 1; n <= 6; n++)
      for (int m = 0; m < 2; m++)
        for (int md = 0; md < 4; md++)
          run(n, m[0], md[1:0], 8'(8'h20 + n * 8 + md), 3'(n + m));

    wr(A_CTRL, 32'h0000_0031);
    wr(A_INIT, 5);
    wr(12'h3A0, 32'h1234_5678);
    rd(12'h3A0, d); check("R10 undefined read", d, 0);
    wr(A_CUR, 32'h99);
    rd(A_CUR, d);  check("R10 cur read-only", d, 5);
    rd(A_INIT, d); check("R10 init untouched", d, 5);
    rd(A_CTRL, d); check("R10 ctrl untouched", d, 32'h31);

    @(negedge clk); tick = 1;
    @(negedge clk); bus_wr = 1; bus_addr = A_INIT; bus_wdata = 9;
    @(negedge clk); bus_wr = 0; tick = 0;
    rd(A_CUR, d); check("R12 write beats tick", d, 9);

    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    wr(A_INIT, 0);
    rd(A_CUR, d); check("R5 stop clears", d, 0);
    tick = 1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      #1 check("R5 no irq after stop", irq, 0);
    end
    tick = 0;
    rd(A_CUR, d); check("R5 stays zero", d, 0);

    wr(A_INIT, 32'hFFFF_FFFF);
    rd(A_CUR, d); check("R11 max load", d, 32'hFFFF_FFFF);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    #1 check("R11 max minus one", bus_rdata, 32'hFFFF_FFFE);
    repeat (3) @(negedge clk);
    #1 check("R4 holds without tick", bus_rdata, 32'hFFFF_FFFE);
    wr(A_INIT, 0);
    rd(A_CUR, d); check("R5 stop mid count", d, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule